// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is the control core of a single-product vending machine. Every item costs 30 units, and the machine takes two kinds of coin: 10-unit coins and 20-unit coins. A coin sensor raises one of two strobes for a single clock cycle when a coin is inserted. The controller adds the coin to the credit it holds. Credit between purchases can be 0, 10 or 20 units.

When a coin takes the credit to exactly 30, the controller raises a dispense pulse for one cycle. When a coin takes it to 40, which can only happen by inserting 20 on top of 20, the controller raises the dispense pulse and a one-coin refund pulse in the same cycle. In both cases the credit goes back to zero. The mechanism acts on the cycle after a pulse. Cycles with no strobe, or with both strobes raised together, leave the credit as it was.

Top module: `vend_credit_ctrl`

## Requirements
- R1: While `rst_ni` is sampled low at a rising clock edge, the credit is set to 0 and `vend_o` and `change_o` are low after that edge.
- R2: A coin that leaves the total below 30 adds its value to the credit: 0+10 gives 10, 0+20 gives 20 and 10+10 gives 20. Both outputs stay low.
- R3: A coin that brings the total to exactly 30 (10+20 or 20+10) raises `vend_o` for the one cycle after the strobe's clock edge. `change_o` stays low and the credit returns to 0.
- R4: A 20-unit coin on a credit of 20 raises `vend_o` and `change_o` together for the one cycle after the strobe's edge, and the credit returns to 0.
- R5: A cycle with neither strobe high keeps the credit unchanged, and both outputs are low in the following cycle.
- R6: A cycle with both strobes high is ignored. The credit is unchanged and both outputs are low in the following cycle.
- R7: `vend_o` and `change_o` are never high for two cycles in a row, and `change_o` is never high without `vend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| coin_small_i | input | 1 | One-cycle strobe: a 10-unit coin was inserted |
| coin_large_i | input | 1 | One-cycle strobe: a 20-unit coin was inserted |
| vend_o | output | 1 | One-cycle pulse: dispense one item |
| change_o | output | 1 | One-cycle pulse: return one 10-unit coin |

## Verification
Both outputs are registered. A strobe sampled at one rising edge therefore shows up at the outputs right after that same edge, and it is gone after the next edge. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, half a cycle after the edge that produced them. The internal credit is not visible at the ports, so after each stimulus the bench feeds 10-unit coins and counts how many it takes to get a vend: 3 minus the credit in tens. The cycle right after every stimulus is also read, to check that the pulses have dropped.

// File: rtl/vend_pkg.sv
// Package vend_pkg
// Purpose: types and constants shared by the vending credit controller.
// Assumes: credit is counted in whole 10-unit steps and the price is three steps.
package vend_pkg;

    localparam int unsigned CREDIT_W    = 2;
    localparam int unsigned PRICE_STEPS = 3;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'd0,
        CR_10 = 2'd1,
        CR_20 = 2'd2
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE  = 2'd0,
        COIN_SMALL = 2'd1,
        COIN_LARGE = 2'd2
    } coin_e;

endpackage

// File: rtl/vend_coin_decode.sv
// Module vend_coin_decode
// Purpose: turns the two coin strobes into one coin code.
// Assumes: the two strobes raised together is an illegal case, and it reads as no coin.
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  small_i,
    input  logic  large_i,
    output coin_e coin_o
);

    // Decode: only a single strobe on its own counts as a coin.
    always_comb begin
        unique case ({large_i, small_i})
            2'b01:   coin_o = COIN_SMALL;
            2'b10:   coin_o = COIN_LARGE;
            default: coin_o = COIN_NONE;
        endcase
    end

endmodule

// File: rtl/vend_credit_step.sv
// Module vend_credit_step
// Purpose: next-credit and purchase logic, purely combinational.
// Assumes: the total can reach at most one step above the price, so change is one coin at most.
module vend_credit_step
    import vend_pkg::*;
(
    input  credit_e credit_i,
    input  coin_e   coin_i,
    output credit_e credit_o,
    output logic    vend_o,
    output logic    change_o
);

    localparam int unsigned SUM_W = CREDIT_W + 1;

    logic [SUM_W-1:0] add_steps;
    logic [SUM_W-1:0] total;

    // Coin value in 10-unit steps.
    always_comb begin
        unique case (coin_i)
            COIN_SMALL: add_steps = SUM_W'(1);
            COIN_LARGE: add_steps = SUM_W'(2);
            default:    add_steps = SUM_W'(0);
        endcase
    end

    // Add the coin and decide whether a purchase completes.
    always_comb begin
        total    = SUM_W'(credit_i) + add_steps;
        vend_o   = (total >= SUM_W'(PRICE_STEPS));
        change_o = (total >  SUM_W'(PRICE_STEPS));
        if (vend_o) begin
            credit_o = CR_0;
        end else begin
            credit_o = credit_e'(total[CREDIT_W-1:0]);
        end
    end

endmodule

// File: rtl/vend_state_reg.sv
// Module vend_state_reg
// Purpose: holds the credit and the registered purchase pulses.
// Assumes: synchronous reset, active low.
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  credit_e credit_d,
    input  logic    vend_d,
    input  logic    change_d,
    output credit_e credit_q,
    output logic    vend_q,
    output logic    change_q
);

    // Load the next credit and outputs; reset clears them all.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            credit_q <= CR_0;
            vend_q   <= 1'b0;
            change_q <= 1'b0;
        end else begin
            credit_q <= credit_d;
            vend_q   <= vend_d;
            change_q <= change_d;
        end
    end

endmodule

// File: rtl/vend_credit_ctrl.sv
// Module vend_credit_ctrl
// Purpose: top of the vending credit controller. It adds up 10- and 20-unit coins
//          and pulses vend (and change when the total is 40) once 30 is reached.
// Assumes: each coin strobe is high for one cycle; both strobes together are ignored.
module vend_credit_ctrl
    import vend_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic coin_small_i,
    input  logic coin_large_i,
    output logic vend_o,
    output logic change_o
);

    coin_e   coin;
    credit_e credit_q;
    credit_e credit_d;
    logic    vend_d;
    logic    change_d;

    vend_coin_decode u_decode (
        .small_i (coin_small_i),
        .large_i (coin_large_i),
        .coin_o  (coin)
    );

    vend_credit_step u_step (
        .credit_i (credit_q),
        .coin_i   (coin),
        .credit_o (credit_d),
        .vend_o   (vend_d),
        .change_o (change_d)
    );

    vend_state_reg u_reg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .credit_d (credit_d),
        .vend_d   (vend_d),
        .change_d (change_d),
        .credit_q (credit_q),
        .vend_q   (vend_o),
        .change_q (change_o)
    );

endmodule

// File: rtl/vend_credit_chk.sv
// Module vend_credit_chk
// Purpose: timing properties of the vending controller, bound to its top.
// Assumes: it is attached through the bind at the end of this file.
module vend_credit_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       coin_small_i,
    input logic       coin_large_i,
    input logic [1:0] credit_q,
    input logic       vend_o,
    input logic       change_o
);

    p_reset_clears_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (credit_q == 2'd0 && !vend_o && !change_o));

    p_credit_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        credit_q != 2'd3);

    p_exact_vend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((credit_q == 2'd1 && coin_large_i && !coin_small_i) ||
         (credit_q == 2'd2 && coin_small_i && !coin_large_i))
        |=> (vend_o && !change_o && credit_q == 2'd0));

    p_vend_with_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (credit_q == 2'd2 && coin_large_i && !coin_small_i)
        |=> (vend_o && change_o && credit_q == 2'd0));

    p_idle_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!coin_small_i && !coin_large_i)
        |=> (credit_q == $past(credit_q) && !vend_o && !change_o));

    p_both_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (coin_small_i && coin_large_i)
        |=> (credit_q == $past(credit_q) && !vend_o && !change_o));

    p_vend_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vend_o |=> !vend_o);

    p_change_needs_vend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        change_o |-> vend_o);

endmodule

bind vend_credit_ctrl vend_credit_chk u_vend_credit_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .coin_small_i (coin_small_i),
    .coin_large_i (coin_large_i),
    .credit_q     (credit_q),
    .vend_o       (vend_o),
    .change_o     (change_o)
);

// File: tb/test_vend_credit_ctrl.sv
// Bench test_vend_credit_ctrl
// Purpose: sweeps every starting credit against every strobe pattern and
//          compares the outputs and the remaining credit with values worked out in the bench.
module test_vend_credit_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coin_s = 1'b0;
    logic coin_l = 1'b0;
    logic vend;
    logic change;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    vend_credit_ctrl i_vend_credit_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .coin_small_i (coin_s),
        .coin_large_i (coin_l),
        .vend_o       (vend),
        .change_o     (change)
    );

    // Compare one value and record the result.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive the strobes for one cycle, sample at the next falling edge.
    task automatic step(input logic s, input logic l, output logic v, output logic c);
        coin_s = s;
        coin_l = l;
        @(negedge clk);
        v = vend;
        c = change;
        coin_s = 1'b0;
        coin_l = 1'b0;
    endtask

    // Synchronous reset for one cycle; the outputs must be low after it (R1).
    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "vend after reset", int'(vend), 0);
        check("R1", "change after reset", int'(change), 0);
        rst_n = 1'b1;
    endtask

    // Feed 10-unit coins until a vend; the count shows the credit that was held.
    task automatic probe(input string req, input int exp_credit);
        logic v;
        logic c;
        int   n;
        n = 0;
        v = 1'b0;
        while (!v && n < 5) begin
            step(1'b1, 1'b0, v, c);
            n++;
        end
        check(req, "coins to next vend", n, 3 - exp_credit);
    endtask

    initial begin
        logic v;
        logic c;
        @(negedge clk);
        do_reset();
        for (int start = 0; start < 3; start++) begin
            for (int pat = 0; pat < 4; pat++) begin
                int    add;
                int    total;
                int    remain;
                string tag;
                do_reset();
                for (int k = 0; k < start; k++) begin
                    step(1'b1, 1'b0, v, c);
                    check("R2", "no vend while building credit", int'(v), 0);
                end
                add    = (pat == 1) ? 1 : (pat == 2) ? 2 : 0;
                total  = start + add;
                remain = (total >= 3) ? 0 : total;
                if (pat == 0)       tag = "R5";
                else if (pat == 3)  tag = "R6";
                else if (total > 3) tag = "R4";
                else if (total == 3) tag = "R3";
                else                tag = "R2";
                step(pat[0], pat[1], v, c);
                check(tag, "vend", int'(v), (total >= 3) ? 1 : 0);
                check(tag, "change", int'(c), (total > 3) ? 1 : 0);
                step(1'b0, 1'b0, v, c);
                check("R7", "vend one cycle later", int'(v), 0);
                check("R7", "change one cycle later", int'(c), 0);
                probe(tag, remain);
            end
        end
        // Reset with credit held must clear it (R1).
        do_reset();
        step(1'b0, 1'b1, v, c);
        do_reset();
        probe("R1", 0);
        // 20 then 20: vend and change together (R4), then 10+10 reaches credit 20 (R2).
        do_reset();
        step(1'b0, 1'b1, v, c);
        step(1'b0, 1'b1, v, c);
        check("R4", "vend on 20+20", int'(v), 1);
        check("R4", "change on 20+20", int'(c), 1);
        step(1'b1, 1'b0, v, c);
        step(1'b1, 1'b0, v, c);
        check("R2", "no vend at 20", int'(v), 0);
        probe("R2", 2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule